// File: doc/BRIEF.md
# ADC Initialization and Sampling Sequencer

This controller times a single analog-to-digital conversion from its start request to its end. When a start is accepted, it powers the analog modules that the chosen input and reference need. It then waits until the slowest of those modules has settled, holds the sample phase open for a programmable number of half ADC clocks, and runs a conversion phase of fixed length. Settling waits are counted in microsecond ticks. The sample and conversion phases are counted on an enable that arrives at twice the ADC clock rate, so a sample window of SAMPDUR plus one half clock can be timed exactly.

In low-latency mode the modules stay powered between conversions. A later conversion that also requests low-latency mode then skips the settling it no longer needs. The block remembers the input and reference of the last completed low-latency conversion. From that record it decides which waits can be dropped and whether the short internal-to-internal reference switch applies. An error flag reports a sample duration that is too short for an internal reference.

Top module: `adc_init_seq`

## Requirements
- R1: After reset every output is low.
- R2: The settling wait, counted in `us_tick_i` pulses, is the largest wait among the modules the configuration enables. The core is always enabled and waits T_CORE. The reference module is enabled when `ref_sel_i[1]`=1 (codes 2 and 3 are internal; 0 is supply and 1 is external pin) and waits T_REF. The temperature sensor is enabled for `in_sel_i`=1 and waits T_TS. The comparator DAC input is enabled for `in_sel_i`=2 and waits T_DAC in every mode.
- R3: `busy_o` rises in the cycle after an accepted start and stays high through the settling, sample and convert phases. `sample_o` and `convert_o` are never high together.
- R4: `sample_o` spans exactly 2·`sampdur_i`+1 `half_tick_i` pulses, including when `sampdur_i`=0.
- R5: `convert_o` spans exactly 2·CONV_CLKS `half_tick_i` pulses. It is followed by a one-cycle `done_o`, and then `busy_o` falls.
- R6: A start while busy, or while `en_i` is low, has no effect on timing, outputs or the number of done pulses.
- R7: If low-latency mode was off at start, all module enables drop after done. If it was on, the enables stay set after done.
- R8: If the previous completed conversion and the new start both have low-latency mode set, the core wait is 0. The temperature-sensor wait is 0 when the input is unchanged, and the reference wait is 0 when the same internal reference is kept.
- R9: Under the conditions of R8, switching from one internal reference to the other waits T_REF_SW. Moving from a non-internal reference to an internal one waits the full T_REF.
- R10: The first conversion after enable, and any conversion that follows one made without low-latency mode, gets the full waits.
- R11: `err_o` is set at an accepted start when the reference is internal and `sampdur_i` < MIN_SD_INT. Otherwise the start clears it. It holds its value until the next accepted start.
- R12: Driving `en_i` low returns the block to idle in the next cycle with all enables low and no done pulse. The next conversion then gets the full waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Block enable |
| lowlat_i | input | 1 | Low-latency mode, sampled at start |
| start_i | input | 1 | Start strobe |
| in_sel_i | input | 2 | Input select: 0/3 pin, 1 temperature sensor, 2 comparator DAC |
| ref_sel_i | input | 2 | Reference select: 0 supply, 1 pin, 2/3 internal |
| sampdur_i | input | SD_W | Sample duration in ADC clocks |
| us_tick_i | input | 1 | One-cycle microsecond tick |
| half_tick_i | input | 1 | Enable at twice the ADC clock rate |
| busy_o | output | 1 | Conversion in progress |
| core_en_o | output | 1 | ADC core power enable |
| ref_en_o | output | 1 | Internal reference enable |
| ts_en_o | output | 1 | Temperature sensor enable |
| dac_en_o | output | 1 | Comparator DAC input enable |
| sample_o | output | 1 | Sample phase |
| convert_o | output | 1 | Convert phase |
| done_o | output | 1 | One-cycle end of conversion |
| err_o | output | 1 | Sample duration too short for internal reference |

## Verification
The bench builds the block with SD_W=4, T_CORE=3, T_REF=9, T_REF_SW=2, T_TS=7, T_DAC=5, CONV_CLKS=3 and MIN_SD_INT=4. Every settling time is distinct, so each measured wait shows which module set the maximum. With the waits this short, chains of a dozen back-to-back low-latency reconfigurations run in a few hundred cycles. The 4-bit duration field also lets the bench reach both zero and the error threshold.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {REF_SUPPLY = 2'd0, REF_PIN = 2'd1, REF_INT_A = 2'd2, REF_INT_B = 2'd3} ref_sel_e;
  typedef enum logic [1:0] {IN_PIN0 = 2'd0, IN_TEMP = 2'd1, IN_DACREF = 2'd2, IN_PIN1 = 2'd3} in_sel_e;
  typedef enum logic [1:0] {ST_IDLE, ST_INIT, ST_SAMPLE, ST_CONV} phase_e;
  localparam int unsigned N_MOD  = 4;
  localparam int unsigned M_CORE = 0;
  localparam int unsigned M_REF  = 1;
  localparam int unsigned M_TS   = 2;
  localparam int unsigned M_DAC  = 3;
  localparam int unsigned REF_INT_BIT = 1;
endpackage

// File: rtl/adc_init_calc.sv
module adc_init_calc
  import adc_seq_pkg::*;
#(
  parameter int unsigned US_W     = 6,
  parameter int unsigned T_CORE   = 6,
  parameter int unsigned T_REF    = 40,
  parameter int unsigned T_REF_SW = 2,
  parameter int unsigned T_TS     = 40,
  parameter int unsigned T_DAC    = 20
) (
  input  logic             warm_i,
  input  logic             lowlat_i,
  input  logic [1:0]       ref_sel_i,
  input  logic [1:0]       in_sel_i,
  input  logic [1:0]       prev_ref_i,
  input  logic [1:0]       prev_in_i,
  output logic [US_W-1:0]  wait_o,
  output logic [N_MOD-1:0] need_o
);
  logic            fast;
  logic [US_W-1:0] mod_wait [N_MOD];

  always_comb begin
    fast           = warm_i & lowlat_i;
    need_o         = '0;
    need_o[M_CORE] = 1'b1;
    need_o[M_REF]  = ref_sel_i[REF_INT_BIT];
    need_o[M_TS]   = (in_sel_i == IN_TEMP);
    need_o[M_DAC]  = (in_sel_i == IN_DACREF);

    mod_wait[M_CORE] = fast ? '0 : US_W'(T_CORE);
    if (fast && prev_ref_i[REF_INT_BIT])
      mod_wait[M_REF] = (prev_ref_i == ref_sel_i) ? '0 : US_W'(T_REF_SW);
    else
      mod_wait[M_REF] = US_W'(T_REF);
    mod_wait[M_TS]  = (fast && prev_in_i == IN_TEMP) ? '0 : US_W'(T_TS);
    mod_wait[M_DAC] = US_W'(T_DAC);

    // modules settle in parallel: the slowest enabled one decides
    wait_o = '0;
    for (int i = 0; i < N_MOD; i++)
      if (need_o[i] && mod_wait[i] > wait_o) wait_o = mod_wait[i];
  end
endmodule

// File: rtl/adc_mod_ctrl.sv
module adc_mod_ctrl
  import adc_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             load_i,
  input  logic [N_MOD-1:0] need_i,
  input  logic             finish_i,
  input  logic             keep_i,
  input  logic [1:0]       ref_sel_i,
  input  logic [1:0]       in_sel_i,
  output logic [N_MOD-1:0] mod_en_o,
  output logic             warm_o,
  output logic [1:0]       prev_ref_o,
  output logic [1:0]       prev_in_o
);
  for (genvar g = 0; g < N_MOD; g++) begin : g_en
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 mod_en_o[g] <= 1'b0;
      else if (!en_i)              mod_en_o[g] <= 1'b0;
      else if (load_i)             mod_en_o[g] <= need_i[g];
      else if (finish_i && !keep_i) mod_en_o[g] <= 1'b0;
    end
  end

  // history of the last finished conversion, used for low-latency shortcuts
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      warm_o     <= 1'b0;
      prev_ref_o <= REF_SUPPLY;
      prev_in_o  <= IN_PIN0;
    end else if (!en_i) begin
      warm_o <= 1'b0;
    end else if (finish_i) begin
      warm_o     <= keep_i;
      prev_ref_o <= ref_sel_i;
      prev_in_o  <= in_sel_i;
    end
  end
endmodule

// File: rtl/adc_phase_timer.sv
module adc_phase_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          step_i,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (step_i) cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == CW'(1));
endmodule

// File: rtl/adc_init_seq.sv
module adc_init_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned SD_W       = 8,
  parameter int unsigned US_W       = 6,
  parameter int unsigned T_CORE     = 6,
  parameter int unsigned T_REF      = 40,
  parameter int unsigned T_REF_SW   = 2,
  parameter int unsigned T_TS       = 40,
  parameter int unsigned T_DAC      = 20,
  parameter int unsigned CONV_CLKS  = 14,
  parameter int unsigned MIN_SD_INT = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            lowlat_i,
  input  logic            start_i,
  input  logic [1:0]      in_sel_i,
  input  logic [1:0]      ref_sel_i,
  input  logic [SD_W-1:0] sampdur_i,
  input  logic            us_tick_i,
  input  logic            half_tick_i,
  output logic            busy_o,
  output logic            core_en_o,
  output logic            ref_en_o,
  output logic            ts_en_o,
  output logic            dac_en_o,
  output logic            sample_o,
  output logic            convert_o,
  output logic            done_o,
  output logic            err_o
);
  localparam int unsigned CONV_LEN = 2 * CONV_CLKS;
  localparam int unsigned CONV_W   = $clog2(CONV_LEN + 1);
  localparam int unsigned CW0      = (US_W > SD_W + 1) ? US_W : SD_W + 1;
  localparam int unsigned CW       = (CW0 > CONV_W) ? CW0 : CONV_W;

  phase_e          state_q, state_d;
  logic [1:0]      ref_q, in_q;
  logic [SD_W-1:0] sd_q;
  logic            ll_q, done_q, err_q;
  logic            accept, fin;
  logic            t_load, t_step, t_last;
  logic [CW-1:0]   t_val;
  logic [US_W-1:0] wait_us;
  logic [N_MOD-1:0] need, mod_en;
  logic            warm;
  logic [1:0]      prev_ref, prev_in;

  assign accept = en_i && start_i && (state_q == ST_IDLE);

  adc_init_calc #(
    .US_W(US_W), .T_CORE(T_CORE), .T_REF(T_REF), .T_REF_SW(T_REF_SW),
    .T_TS(T_TS), .T_DAC(T_DAC)
  ) i_calc (
    .warm_i    (warm),
    .lowlat_i  (lowlat_i),
    .ref_sel_i (ref_sel_i),
    .in_sel_i  (in_sel_i),
    .prev_ref_i(prev_ref),
    .prev_in_i (prev_in),
    .wait_o    (wait_us),
    .need_o    (need)
  );

  adc_phase_timer #(.CW(CW)) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (t_load),
    .load_val_i(t_val),
    .step_i    (t_step),
    .last_o    (t_last)
  );

  adc_mod_ctrl i_mods (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .load_i    (accept),
    .need_i    (need),
    .finish_i  (fin),
    .keep_i    (ll_q),
    .ref_sel_i (ref_q),
    .in_sel_i  (in_q),
    .mod_en_o  (mod_en),
    .warm_o    (warm),
    .prev_ref_o(prev_ref),
    .prev_in_o (prev_in)
  );

  always_comb begin
    state_d = state_q;
    t_load  = 1'b0;
    t_step  = 1'b0;
    t_val   = '0;
    fin     = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        t_load = 1'b1;
        if (wait_us == '0) begin
          state_d = ST_SAMPLE;
          t_val   = CW'({sampdur_i, 1'b1});
        end else begin
          state_d = ST_INIT;
          t_val   = CW'(wait_us);
        end
      end
      ST_INIT: if (us_tick_i) begin
        if (t_last) begin
          state_d = ST_SAMPLE;
          t_load  = 1'b1;
          t_val   = CW'({sd_q, 1'b1});
        end else t_step = 1'b1;
      end
      ST_SAMPLE: if (half_tick_i) begin
        if (t_last) begin
          state_d = ST_CONV;
          t_load  = 1'b1;
          t_val   = CW'(CONV_LEN);
        end else t_step = 1'b1;
      end
      ST_CONV: if (half_tick_i) begin
        if (t_last) begin
          state_d = ST_IDLE;
          fin     = 1'b1;
        end else t_step = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
    if (!en_i) begin
      state_d = ST_IDLE;
      t_load  = 1'b0;
      t_step  = 1'b0;
      fin     = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ref_q   <= REF_SUPPLY;
      in_q    <= IN_PIN0;
      sd_q    <= '0;
      ll_q    <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= fin;
      if (accept) begin
        ref_q <= ref_sel_i;
        in_q  <= in_sel_i;
        sd_q  <= sampdur_i;
        ll_q  <= lowlat_i;
        err_q <= ref_sel_i[REF_INT_BIT] && (int'(sampdur_i) < int'(MIN_SD_INT));
      end
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign sample_o  = (state_q == ST_SAMPLE);
  assign convert_o = (state_q == ST_CONV);
  assign done_o    = done_q;
  assign err_o     = err_q;
  assign core_en_o = mod_en[M_CORE];
  assign ref_en_o  = mod_en[M_REF];
  assign ts_en_o   = mod_en[M_TS];
  assign dac_en_o  = mod_en[M_DAC];
endmodule

// File: rtl/adc_init_seq_chk.sv
module adc_init_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic start_i,
  input logic half_tick_i,
  input logic busy_o,
  input logic core_en_o,
  input logic ref_en_o,
  input logic ts_en_o,
  input logic dac_en_o,
  input logic sample_o,
  input logic convert_o,
  input logic done_o
);
  AST_PHASE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sample_o, convert_o})); // R3
  AST_PHASE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_o || convert_o) |-> busy_o); // R3
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && start_i && !busy_o) |=> busy_o); // R3
  AST_SAMPLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_o && !half_tick_i && en_i) |=> sample_o); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R5
  AST_DONE_AFTER_CONV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(convert_o) && !busy_o)); // R5
  AST_CORE_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> core_en_o); // R2
  AST_MOD_NEEDS_CORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_en_o || ts_en_o || dac_en_o) |-> core_en_o); // R7
  AST_DISABLE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!busy_o && !core_en_o && !done_o)); // R12
endmodule

bind adc_init_seq adc_init_seq_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .start_i    (start_i),
  .half_tick_i(half_tick_i),
  .busy_o     (busy_o),
  .core_en_o  (core_en_o),
  .ref_en_o   (ref_en_o),
  .ts_en_o    (ts_en_o),
  .dac_en_o   (dac_en_o),
  .sample_o   (sample_o),
  .convert_o  (convert_o),
  .done_o     (done_o)
);

// File: tb/test_adc_init_seq.sv
module test_adc_init_seq;
  localparam int SD_W = 4, US_W = 6, T_CORE = 3, T_REF = 9, T_REF_SW = 2;
  localparam int T_TS = 7, T_DAC = 5, CONV_CLKS = 3, MIN_SD = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_ni = 1'b0, en = 1'b0, lowlat = 1'b0, start = 1'b0;
  logic [1:0] in_sel = 2'd0, ref_sel = 2'd0;
  logic [SD_W-1:0] sampdur = '0;
  logic us_tick = 1'b0, half_tick = 1'b0;
  logic busy, core_en, ref_en, ts_en, dac_en, sample, convert, done, err;

  adc_init_seq #(
    .SD_W(SD_W), .US_W(US_W), .T_CORE(T_CORE), .T_REF(T_REF), .T_REF_SW(T_REF_SW),
    .T_TS(T_TS), .T_DAC(T_DAC), .CONV_CLKS(CONV_CLKS), .MIN_SD_INT(MIN_SD)
  ) i_adc_init_seq (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .lowlat_i(lowlat), .start_i(start),
    .in_sel_i(in_sel), .ref_sel_i(ref_sel), .sampdur_i(sampdur), .us_tick_i(us_tick),
    .half_tick_i(half_tick), .busy_o(busy), .core_en_o(core_en), .ref_en_o(ref_en),
    .ts_en_o(ts_en), .dac_en_o(dac_en), .sample_o(sample), .convert_o(convert),
    .done_o(done), .err_o(err)
  );

  int checks = 0, fails = 0;
  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int cyc = 0;
  always @(negedge clk) begin
    cyc++;
    us_tick   <= (cyc % 4 == 0);
    half_tick <= (cyc % 2 == 1);
  end

  // behavioural reference model
  int m_phase = 0, m_left = 0, m_sd = 0;
  bit m_done = 0, m_err = 0, m_warm = 0, m_ll = 0;
  bit [3:0] m_en = '0;  // {dac, ts, ref, core}
  int m_ref = 0, m_in = 0, m_pref = 0, m_pin = 0;
  int n_init = 0, n_samp = 0, n_conv = 0, n_done = 0;
  bit d_init = 0, d_samp = 0, d_conv = 0;

  function automatic int max2(int a, int b); return (a > b) ? a : b; endfunction

  function automatic int model_wait(bit ll, int rs, int is);
    bit f = ll && m_warm;
    int w = f ? 0 : T_CORE;
    if (rs >= 2) w = max2(w, (f && m_pref >= 2) ? ((m_pref == rs) ? 0 : T_REF_SW) : T_REF);
    if (is == 1) w = max2(w, (f && m_pin == 1) ? 0 : T_TS);
    if (is == 2) w = max2(w, T_DAC);
    return w;
  endfunction

  always @(posedge clk) begin
    if (d_init && us_tick) n_init++;
    if (d_samp && half_tick) n_samp++;
    if (d_conv && half_tick) n_conv++;
    m_done = 0;
    if (!rst_ni) begin
      m_phase = 0; m_err = 0; m_warm = 0; m_en = '0; m_pref = 0; m_pin = 0;
    end else if (!en) begin
      m_phase = 0; m_en = '0; m_warm = 0;
    end else begin
      case (m_phase)
        0: if (start) begin
          int w;
          w = model_wait(lowlat, ref_sel, in_sel);
          m_ref = ref_sel; m_in = in_sel; m_sd = sampdur; m_ll = lowlat;
          m_err = (ref_sel >= 2) && (sampdur < MIN_SD);
          m_en = {in_sel == 2, in_sel == 1, ref_sel >= 2, 1'b1};
          if (w == 0) begin m_phase = 2; m_left = 2 * m_sd + 1; end
          else begin m_phase = 1; m_left = w; end
        end
        1: if (us_tick) begin
          m_left--;
          if (m_left == 0) begin m_phase = 2; m_left = 2 * m_sd + 1; end
        end
        2: if (half_tick) begin
          m_left--;
          if (m_left == 0) begin m_phase = 3; m_left = 2 * CONV_CLKS; end
        end
        default: if (half_tick) begin
          m_left--;
          if (m_left == 0) begin
            m_phase = 0; m_done = 1; m_warm = m_ll;
            m_pref = m_ref; m_pin = m_in;
            if (!m_ll) m_en = '0;
          end
        end
      endcase
    end
    #2;
    if (rst_ni) begin
      logic [8:0] exp_v, act_v;
      exp_v = {m_phase != 0, m_phase == 2, m_phase == 3, m_done, m_err, m_en};
      act_v = {busy, sample, convert, done, err, dac_en, ts_en, ref_en, core_en};
      chk(exp_v == act_v, "R3 model compare", int'(act_v), int'(exp_v));
    end
    if (done) n_done++;
    d_init = busy && !sample && !convert;
    d_samp = sample;
    d_conv = convert;
  end

  task automatic pulse_start(bit ll, int rs, int is, int sd);
    @(negedge clk);
    lowlat = ll; ref_sel = 2'(rs); in_sel = 2'(is); sampdur = SD_W'(sd); start = 1'b1;
    n_init = 0; n_samp = 0; n_conv = 0; n_done = 0;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 3000 && n_done == 0; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic conv(bit ll, int rs, int is, int sd, int exp_w, string tag);
    pulse_start(ll, rs, is, sd);
    wait_done();
    chk(n_init == exp_w, tag, n_init, exp_w);
    chk(n_samp == 2 * sd + 1, "R4 sample window", n_samp, 2 * sd + 1);
    chk(n_conv == 2 * CONV_CLKS, "R5 convert length", n_conv, 2 * CONV_CLKS);
    chk(n_done == 1, "R5 done pulse", n_done, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({busy, core_en, ref_en, ts_en, dac_en, sample, convert, done, err} == '0,
        "R1 reset state", int'({busy, core_en, sample, convert, done, err}), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    en = 1'b1;

    // full waits, maximum over enabled modules
    conv(0, 1, 0, 3, T_CORE, "R2 core only");
    chk(core_en == 0, "R7 enables drop", core_en, 0);
    conv(0, 2, 1, 5, T_REF, "R2 ref+ts");
    conv(0, 0, 1, 4, T_TS, "R2 ts");
    conv(0, 1, 2, 0, T_DAC, "R2 dac, R4 sampdur zero");

    // error flag
    conv(0, 3, 0, 2, T_REF, "R2 int ref");
    chk(err == 1, "R11 short sampdur", err, 1);
    conv(0, 3, 0, 4, T_REF, "R2 int ref");
    chk(err == 0, "R11 at threshold", err, 0);
    conv(0, 1, 0, 1, T_CORE, "R2 pin ref");
    chk(err == 0, "R11 non-internal ref", err, 0);

    // low-latency chains
    conv(1, 2, 1, 4, T_REF, "R10 first lowlat");
    chk({core_en, ref_en, ts_en} == 3'b111, "R7 enables kept", int'({core_en, ref_en, ts_en}), 7);
    conv(1, 2, 1, 4, 0, "R8 same config");
    conv(1, 3, 1, 4, T_REF_SW, "R9 internal switch");
    conv(1, 1, 1, 1, 0, "R8 non-internal ref");
    chk(ref_en == 0, "R7 ref dropped", ref_en, 0);
    conv(1, 2, 1, 4, T_REF, "R9 pin to internal");
    conv(1, 2, 2, 4, T_DAC, "R8 dac always waits");
    conv(1, 2, 0, 4, 0, "R8 pin input");
    conv(1, 2, 1, 4, T_TS, "R8 ts re-settle");
    conv(0, 2, 1, 4, T_REF, "R10 lowlat off");
    chk({core_en, ref_en, ts_en} == 3'b000, "R7 enables drop", int'({core_en, ref_en, ts_en}), 0);
    conv(1, 2, 1, 4, T_REF, "R10 after non-lowlat");

    // start while busy is ignored
    pulse_start(0, 1, 0, 2);
    repeat (6) @(negedge clk);
    ref_sel = 2'd2; in_sel = 2'd1; sampdur = 4'd9; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    chk(n_init == T_CORE, "R6 busy start wait", n_init, T_CORE);
    chk(n_samp == 5, "R6 busy start sample", n_samp, 5);
    repeat (20) @(negedge clk);
    chk(busy == 0 && n_done == 1, "R6 no extra conversion", n_done, 1);

    // start while disabled
    en = 1'b0;
    pulse_start(0, 1, 0, 2);
    repeat (5) @(negedge clk);
    chk(busy == 0, "R6 disabled start", busy, 0);
    en = 1'b1;

    // abort by disable
    conv(1, 2, 1, 4, T_REF, "R10 warm-up");
    pulse_start(1, 2, 1, 4);
    repeat (8) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(busy == 0 && core_en == 0 && ts_en == 0, "R12 abort", int'({busy, core_en, ts_en}), 0);
    repeat (30) @(negedge clk);
    chk(n_done == 0, "R12 no done", n_done, 0);
    en = 1'b1;
    conv(1, 2, 1, 4, T_REF, "R12 full wait after re-enable");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule